// File: doc/BRIEF.md
# Subword-Parallel Precision-Scalable Multiply-Accumulate Unit

This block is a single-cycle multiply-accumulate unit with a 16-bit operand path that can be re-split at run time. It can form one 16-bit product, two 8-bit products or four 4-bit products per clock. Each product is added into its own slice of a 48-bit accumulator, and carries never pass between slices. Before the multiply, every operand subword can be reduced in precision. The unit rounds it and then clears a chosen number of its low-order bits.

A guard input marks a cycle whose operands are known to be zero. In a guarded cycle the multiply-accumulate is skipped. The accumulator keeps its value and the values that reach the multipliers are frozen. A clear input starts a new output by loading the current products in place of the old sum, so no idle cycle is needed between outputs. All results show up on the accumulator output one clock edge after the inputs are sampled.

Top module: `spmac_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the accumulator becomes all zeros.
- R2: `mode` selects the lane split. Code 0 gives one 16-bit lane, code 1 gives two 8-bit lanes, code 2 gives four 4-bit lanes, and code 3 behaves like code 0. Lane i takes bits [i*W +: W] of both `wgt` and `feat`, where W = 16/lanes. Operands are signed two's complement and each lane's product is signed.
- R3: Lane i of the accumulator occupies bits [i*L +: L], where L = 48/lanes. Each product is sign-extended to L bits and added modulo 2^L. No carry or borrow reaches another lane.
- R4: Precision reduction. `mask_cnt` is clamped to at most W-1, giving m. If m is 0 the subword is used unchanged. Otherwise 2^(m-1) is added, the result saturates at 2^(W-1)-1, and the low m bits are cleared. This is applied to both operands in every lane.
- R5: When `en` and `clr` are both high and `guard` is low, each lane of the accumulator is loaded with its own product, and the previous content is discarded.
- R6: When `en` is low, the accumulator keeps its value whatever `clr`, `guard`, `mode` and the operands are.
- R7: When `en` and `guard` are high and `clr` is low, the accumulator keeps its value and the operands seen by the multipliers do not change.
- R8: When `en`, `guard` and `clr` are all high, the accumulator becomes all zeros.
- R9: A change of `mode` leaves the accumulator bits untouched. The next operation splits those bits using the new mode's lane boundaries.
- R10: An accepted operation is visible on `acc_o` right after the rising edge that samples it, with no further latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Operation enable |
| clr | input | 1 | Start a new sum: load products instead of adding |
| guard | input | 1 | Zero-operand flag: skip the multiply-accumulate |
| mode | input | 2 | Lane split: 0 = 1x16, 1 = 2x8, 2 = 4x4, 3 = 1x16 |
| mask_cnt | input | 4 | Low-order bits to round away per subword |
| wgt | input | 16 | Packed weight subwords |
| feat | input | 16 | Packed feature subwords |
| acc_o | output | 48 | Packed per-lane accumulators |

## Verification
The clear and the guard can be asserted in the same cycle. The bench provokes this by first building up a nonzero sum and then driving `en`, `clr` and `guard` together, with operands whose product would be nonzero. The scoreboard expects all zeros in that case, and it expects an unchanged sum when only the guard is set. Mode changes in the middle of a running sum are mixed into a long stretch of random traffic. A lane-exact reference model judges each result, so any carry that crosses a lane boundary or any wrong reinterpretation of the bits shows up as a mismatch.

// File: rtl/spmac_pkg.sv
package spmac_pkg;

   typedef enum logic [1:0] {
      SPLIT_X1  = 2'd0,
      SPLIT_X2  = 2'd1,
      SPLIT_X4  = 2'd2,
      SPLIT_ALT = 2'd3
   } split_e;

   localparam int LOG_LANES_MAX = 2;
   localparam int VARIANTS      = LOG_LANES_MAX + 1;

   function automatic int variant_of(input logic [1:0] code);
      case (code)
         SPLIT_X2: return 1;
         SPLIT_X4: return 2;
         default:  return 0;
      endcase
   endfunction

endpackage

// File: rtl/spmac_reduce.sv
module spmac_reduce #(
   parameter int W      = 8,
   parameter int MASK_W = 4
) (
   input  logic [W-1:0]      x_i,
   input  logic [MASK_W-1:0] m_i,
   output logic [W-1:0]      y_o
);
   localparam logic [MASK_W-1:0] M_MAX = MASK_W'(W - 1);

   generate
      if ((1 << MASK_W) < W) begin : g_bad_mask
         $error("spmac_reduce: MASK_W too narrow for subword width");
      end
   endgenerate

   logic [MASK_W-1:0] m_eff;
   logic [W-1:0]      half;
   logic [W-1:0]      rounded;
   logic [W-1:0]      limited;
   logic [W-1:0]      low_bits;
   logic              pos_ovf;

   always_comb begin
      m_eff    = (m_i > M_MAX) ? M_MAX : m_i;
      half     = (m_eff == '0) ? '0 : (W'(1) << (m_eff - MASK_W'(1)));
      rounded  = x_i + half;
      // only a non-negative operand can pass the positive limit
      pos_ovf  = ~x_i[W-1] & rounded[W-1];
      limited  = pos_ovf ? {1'b0, {(W-1){1'b1}}} : rounded;
      low_bits = (W'(1) << m_eff) - W'(1);
      y_o      = limited & ~low_bits;
   end

endmodule

// File: rtl/spmac_lanes.sv
module spmac_lanes #(
   parameter int LANES  = 1,
   parameter int DATA_W = 16,
   parameter int ACC_W  = 48,
   parameter int MASK_W = 4
) (
   input  logic [DATA_W-1:0] w_i,
   input  logic [DATA_W-1:0] f_i,
   input  logic [MASK_W-1:0] m_i,
   input  logic [ACC_W-1:0]  acc_i,
   input  logic              clr_i,
   output logic [ACC_W-1:0]  next_o
);
   localparam int SW = DATA_W / LANES;
   localparam int LW = ACC_W / LANES;
   localparam int PW = 2 * SW;

   generate
      if (DATA_W % LANES != 0 || ACC_W % LANES != 0) begin : g_bad_split
         $error("spmac_lanes: widths not divisible by lane count");
      end
      if (LW < PW) begin : g_bad_acc
         $error("spmac_lanes: lane accumulator narrower than product");
      end
   endgenerate

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [SW-1:0]        w_red;
      logic [SW-1:0]        f_red;
      logic signed [PW-1:0] prod;
      logic [LW-1:0]        prod_ext;
      logic [LW-1:0]        acc_lane;

      spmac_reduce #(.W(SW), .MASK_W(MASK_W)) u_red_w (
         .x_i (w_i[i*SW +: SW]),
         .m_i (m_i),
         .y_o (w_red)
      );

      spmac_reduce #(.W(SW), .MASK_W(MASK_W)) u_red_f (
         .x_i (f_i[i*SW +: SW]),
         .m_i (m_i),
         .y_o (f_red)
      );

      always_comb begin
         prod     = $signed(w_red) * $signed(f_red);
         prod_ext = {{(LW-PW){prod[PW-1]}}, prod};
         acc_lane = acc_i[i*LW +: LW];
      end

      // each lane adds in its own width so the carry out is dropped here
      assign next_o[i*LW +: LW] = clr_i ? prod_ext : (acc_lane + prod_ext);
   end

endmodule

// File: rtl/spmac_top.sv
module spmac_top
   import spmac_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ACC_W  = 48,
   parameter int MASK_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              clr,
   input  logic              guard,
   input  logic [1:0]        mode,
   input  logic [MASK_W-1:0] mask_cnt,
   input  logic [DATA_W-1:0] wgt,
   input  logic [DATA_W-1:0] feat,
   output logic [ACC_W-1:0]  acc_o
);
   localparam int MAX_LANES = 1 << LOG_LANES_MAX;

   generate
      if (DATA_W % MAX_LANES != 0 || ACC_W % MAX_LANES != 0) begin : g_bad_top
         $error("spmac_top: widths must split into the widest lane count");
      end
   endgenerate

   logic              active;
   logic [DATA_W-1:0] held_w, held_f;
   logic [DATA_W-1:0] mul_w, mul_f;
   logic [ACC_W-1:0]  acc_q;
   logic [ACC_W-1:0]  acc_d;
   logic [ACC_W-1:0]  cand [VARIANTS];

   // operand isolation: idle or guarded cycles present the last used operands
   assign active = en & ~guard & ~rst;
   assign mul_w  = active ? wgt  : held_w;
   assign mul_f  = active ? feat : held_f;

   always_ff @(posedge clk) begin
      if (rst) begin
         held_w <= '0;
         held_f <= '0;
      end else if (active) begin
         held_w <= wgt;
         held_f <= feat;
      end
   end

   for (genvar k = 0; k < VARIANTS; k++) begin : g_split
      spmac_lanes #(
         .LANES  (1 << k),
         .DATA_W (DATA_W),
         .ACC_W  (ACC_W),
         .MASK_W (MASK_W)
      ) u_lanes (
         .w_i    (mul_w),
         .f_i    (mul_f),
         .m_i    (mask_cnt),
         .acc_i  (acc_q),
         .clr_i  (clr),
         .next_o (cand[k])
      );
   end

   always_comb begin
      acc_d = acc_q;
      if (en) begin
         if (guard) acc_d = clr ? '0 : acc_q;
         else       acc_d = cand[variant_of(mode)];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) acc_q <= '0;
      else     acc_q <= acc_d;
   end

   assign acc_o = acc_q;

   // R1: reset empties the accumulator
   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> acc_o == '0);

   // R6: disabled cycles leave the sum alone
   p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !en |=> acc_o == $past(acc_o));

   // R7: guarded accumulate keeps the sum
   p_guard_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (en && guard && !clr) |=> acc_o == $past(acc_o));

   // R7: multiplier operands frozen whenever no operation runs
   p_operand_freeze_r7: assert property (@(posedge clk) disable iff (rst)
      !active |-> ($stable(mul_w) && $stable(mul_f)));

   // R8: guarded clear gives zero
   p_guard_clear_r8: assert property (@(posedge clk) disable iff (rst)
      (en && guard && clr) |=> acc_o == '0);

endmodule

// File: tb/spmac_top_bench.sv
`timescale 1ns/1ps
module spmac_top_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en = 1'b0, clr = 1'b0, guard = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic [3:0]  mask_cnt = 4'd0;
   logic [15:0] wgt = '0, feat = '0;
   logic [47:0] acc_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   typedef struct {
      logic [47:0] exp;
      string       req;
   } item_t;

   item_t       sb_q[$];
   logic [47:0] model_acc = '0;

   always #2.5 clk = ~clk;

   spmac_top u_spmac_top (
      .clk(clk), .rst(rst), .en(en), .clr(clr), .guard(guard),
      .mode(mode), .mask_cnt(mask_cnt), .wgt(wgt), .feat(feat), .acc_o(acc_o)
   );

   function automatic longint reduce_ref(input logic [15:0] v, input int i,
                                         input int sw, input int m);
      longint x;
      int     mm;
      x = (longint'(v) >> (i * sw)) & ((longint'(1) << sw) - 1);
      if (x >= (longint'(1) << (sw - 1))) x -= (longint'(1) << sw);
      mm = (m > sw - 1) ? sw - 1 : m;
      if (mm > 0) begin
         x += longint'(1) << (mm - 1);
         if (x > (longint'(1) << (sw - 1)) - 1) x = (longint'(1) << (sw - 1)) - 1;
         x = x & ~((longint'(1) << mm) - 1);
      end
      return x;
   endfunction

   function automatic logic [47:0] step_ref(input logic [47:0] acc, input logic [1:0] md,
                                            input int m, input logic [15:0] w,
                                            input logic [15:0] f, input bit e,
                                            input bit c, input bit g);
      int          n, sw, lw;
      logic [47:0] r;
      if (!e) return acc;
      if (g)  return c ? 48'd0 : acc;
      n  = (md == 2'd1) ? 2 : (md == 2'd2) ? 4 : 1;
      sw = 16 / n;
      lw = 48 / n;
      r  = acc;
      for (int i = 0; i < n; i++) begin
         longint lm, cur, nv, p;
         p   = reduce_ref(w, i, sw, m) * reduce_ref(f, i, sw, m);
         lm  = (longint'(1) << lw) - 1;
         cur = (longint'(acc) >> (i * lw)) & lm;
         nv  = (c ? p : cur + p) & lm;
         r   = (r & ~(48'(lm) << (i * lw))) | (48'(nv) << (i * lw));
      end
      return r;
   endfunction

   task automatic drive(input bit e, input bit c, input bit g, input logic [1:0] md,
                        input int m, input logic [15:0] w, input logic [15:0] f,
                        input string req);
      item_t it;
      @(negedge clk);
      en = e; clr = c; guard = g; mode = md; mask_cnt = 4'(m); wgt = w; feat = f;
      model_acc = step_ref(model_acc, md, m, w, f, e, c, g);
      it.exp = model_acc;
      it.req = req;
      sb_q.push_back(it);
   endtask

   // monitor: compare one result per edge while items are pending
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (acc_o !== it.exp) begin
               errors++;
               $display("FAIL %s actual=%h expected=%h", it.req, acc_o, it.exp);
            end
         end
      end
   end

   task automatic report;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL timeout actual=running expected=finished");
         report();
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1;
      checks++;
      if (acc_o !== 48'd0) begin
         errors++;
         $display("FAIL R1 actual=%h expected=%h", acc_o, 48'd0);
      end
      @(negedge clk);
      rst = 1'b0;

      // R2/R10: single 16-bit lane, clear then accumulate
      drive(1, 1, 0, 2'd0, 0, 16'd3, 16'hFFFB, "R10 R5 x1 clear");
      drive(1, 0, 0, 2'd0, 0, 16'h8000, 16'h8000, "R2 x1 extremes");
      drive(1, 0, 0, 2'd3, 0, 16'h1234, 16'hFF00, "R2 code3 as x1");
      // R2: two 8-bit lanes
      drive(1, 1, 0, 2'd1, 0, 16'h7F80, 16'h02FF, "R2 x2 lanes");
      drive(1, 0, 0, 2'd1, 0, 16'h80FF, 16'h8001, "R2 x2 signs");
      // R2/R5: four 4-bit lanes
      drive(1, 1, 0, 2'd2, 0, 16'h7F18, 16'h2389, "R5 x4 clear");
      // R3: lane wrap without cross-lane carry
      for (int k = 0; k < 40; k++)
         drive(1, 0, 0, 2'd2, 0, 16'h8881, 16'h888F, "R3 x4 wrap");
      // R9: mode change keeps bits
      drive(1, 0, 0, 2'd1, 0, 16'h0505, 16'h0303, "R9 x4 to x2");
      drive(1, 0, 0, 2'd0, 0, 16'h0100, 16'h0100, "R9 x2 to x1");
      // R4: rounding, saturation, clamping
      drive(1, 1, 0, 2'd0, 4, 16'h0008, 16'h0001, "R4 round up");
      drive(1, 1, 0, 2'd0, 4, 16'h0007, 16'h0100, "R4 round to zero");
      drive(1, 1, 0, 2'd0, 4, 16'h7FFF, 16'h0010, "R4 saturate");
      drive(1, 1, 0, 2'd0, 15, 16'hC123, 16'h4000, "R4 max mask");
      drive(1, 1, 0, 2'd2, 9, 16'h48C3, 16'h8888, "R4 x4 clamp");
      drive(1, 1, 0, 2'd1, 12, 16'h7F81, 16'h40C0, "R4 x2 clamp");
      drive(1, 0, 0, 2'd1, 2, 16'hF3FE, 16'h0506, "R4 x2 negative round");
      // R6: idle ignores clear and operands
      drive(0, 1, 0, 2'd2, 0, 16'h7777, 16'h7777, "R6 idle clear");
      drive(0, 0, 1, 2'd0, 0, 16'h1111, 16'h2222, "R6 idle guard");
      // R7: guarded accumulate holds
      drive(1, 0, 1, 2'd0, 0, 16'h1234, 16'h5678, "R7 guard hold");
      drive(1, 0, 0, 2'd0, 0, 16'h0002, 16'h0003, "R7 resume");
      // R8: guard and clear together
      drive(1, 1, 1, 2'd1, 0, 16'h7F7F, 16'h7F7F, "R8 guard clear");
      drive(1, 0, 0, 2'd1, 0, 16'h0101, 16'hFF02, "R8 after zero");
      // random mixture of all controls
      for (int k = 0; k < 300; k++) begin
         logic [31:0] r;
         r = $urandom;
         drive(r[0] | r[1], r[2] & r[3], r[4] & r[5], r[7:6], int'(r[11:8]),
               16'($urandom), 16'($urandom), "R2 R9 random");
      end
      drive(0, 0, 0, 2'd0, 0, 16'h0, 16'h0, "R6 final idle");
      repeat (3) @(posedge clk);
      #2;
      done = 1'b1;
      report();
   end

endmodule